// File: doc/BRIEF.md
# Two-State Local Bus Cycle Sequencer

This block runs one local-bus transfer at a time. Each transfer has a single status state followed by one or more command states. A requester offers a transfer type (read or write) and an address. The sequencer takes the request only when it is idle, or when the current transfer is in its final command state. A taken request starts the status state on the next clock. In the status state the block drives a two-bit status code and pulses the address latch enable. From there it moves straight into command states.

The command states repeat once per clock until the shared ready input is sampled high, and that clock ends the transfer. The leading edge of the active-low read or write command strobe can be held back with a command-delay input. The strobe is released on the clock after ready is sampled. If a new request is waiting when a transfer ends, the next status state follows at once, so back-to-back transfers run with no idle clocks. No output marks the command state itself.

Top module: `busCycleSeq`

## Requirements
- R1: After reset, and in every idle cycle, the outputs are: status 2'b11, ale low, rdN high and wrN high. With no request, the block stays idle, and ready or cmdDelay have no effect there.
- R2: reqAccept is high in a cycle exactly when reqValid is high and the block is either idle or in a command state with ready high. The cycle after an accepted request is a status state.
- R3: A status state lasts exactly one clock. In it, status is 2'b01 for a read (reqWrite low) or 2'b10 for a write (reqWrite high), and ale is high. In every other cycle, status is 2'b11 and ale is low.
- R4: addrOut shows the accepted address from the status state onward. It changes only when the next status state begins.
- R5: The first command state follows the status state directly. Command states repeat, one per clock, until ready is sampled high in a command state. Ready in a status state does not end the transfer.
- R6: A read drives only rdN and a write drives only wrN. The strobe goes low in the cycle after the first clock edge where cmdDelay is low. cmdDelay is sampled at the edge that ends the status state and at each later command-state edge.
- R7: The strobe goes high again in the cycle after ready is sampled high. A request pending at that edge starts its status state in that same cycle, with no idle cycle between the two transfers.
- R8: A request offered during a status state, or during a command state with ready low, is ignored: reqAccept stays low and addrOut stays unchanged.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A transfer request is offered |
| reqWrite | input | 1 | Request type: 1 write, 0 read |
| reqAddr | input | ADDR_W | Request address |
| cmdDelay | input | 1 | Holds off the leading edge of the command strobe |
| ready | input | 1 | Marks the final command state |
| reqAccept | output | 1 | The offered request is taken this cycle |
| status | output | 2 | Status code: 01 read, 10 write, 11 inactive |
| ale | output | 1 | Address latch enable, high during the status state |
| addrOut | output | ADDR_W | Address of the current transfer |
| rdN | output | 1 | Active-low read command strobe |
| wrN | output | 1 | Active-low write command strobe |

## Verification
The bench runs back-to-back transfers in both directions.
- A design that put an idle cycle between chained transfers would show status 11 where the next status code is due.
- The bench holds cmdDelay high for zero, one and two sampling edges. A design that counted the status-state edge wrongly would drop the strobe one cycle early or late.
- The bench drives ready high during a status state. A design that honoured it would skip the command state.
- The bench offers stray requests in the middle of a transfer. A design that took them would show a changed address or a raised reqAccept.

// File: rtl/busCycleSeqPkg.sv
package busCycleSeqPkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_STAT = 2'd1,
    PH_CMD  = 2'd2
  } phase_e;

  localparam logic [1:0] ST_READ  = 2'b01;
  localparam logic [1:0] ST_WRITE = 2'b10;
  localparam logic [1:0] ST_NONE  = 2'b11;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // load the offered request
    logic inStatus;  // current cycle is the status state
    logic cmdSet;    // command strobe becomes active next cycle
    logic cmdClr;    // command strobe becomes inactive next cycle
  } seqCtl_t;

endpackage

// File: rtl/busCycleSeqCtrl.sv
module busCycleSeqCtrl
  import busCycleSeqPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    cmdDelay,
  input  logic    ready,
  output seqCtl_t ctl,
  output logic    reqAccept
);

  phase_e phase, phaseNext;
  logic   lastCmd;

  assign lastCmd   = (phase == PH_CMD) && ready;
  assign reqAccept = reqValid && ((phase == PH_IDLE) || lastCmd);

  always_comb begin
    phaseNext = phase;
    case (phase)
      PH_IDLE: if (reqValid) phaseNext = PH_STAT;
      PH_STAT: phaseNext = PH_CMD;
      PH_CMD:  if (ready) phaseNext = reqValid ? PH_STAT : PH_IDLE;
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  always_comb begin
    ctl.capture  = reqAccept;
    ctl.inStatus = (phase == PH_STAT);
    ctl.cmdClr   = lastCmd;
    ctl.cmdSet   = !cmdDelay && ((phase == PH_STAT) || ((phase == PH_CMD) && !ready));
  end

endmodule

// File: rtl/busCycleSeqPath.sv
module busCycleSeqPath
  import busCycleSeqPkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic [1:0]        status,
  output logic              ale,
  output logic [ADDR_W-1:0] addrOut,
  output logic              rdN,
  output logic              wrN
);

  logic [ADDR_W-1:0] addrQ;
  logic              isWrite;
  logic              cmdOn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      isWrite <= 1'b0;
    end else if (ctl.capture) begin
      addrQ   <= reqAddr;
      isWrite <= reqWrite;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           cmdOn <= 1'b0;
    else if (ctl.cmdClr) cmdOn <= 1'b0;
    else if (ctl.cmdSet) cmdOn <= 1'b1;
  end

  assign addrOut = addrQ;
  assign ale     = ctl.inStatus;
  assign status  = !ctl.inStatus ? ST_NONE : (isWrite ? ST_WRITE : ST_READ);
  assign rdN     = !(cmdOn && !isWrite);
  assign wrN     = !(cmdOn && isWrite);

endmodule

// File: rtl/busCycleSeq.sv
module busCycleSeq
  import busCycleSeqPkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              cmdDelay,
  input  logic              ready,
  output logic              reqAccept,
  output logic [1:0]        status,
  output logic              ale,
  output logic [ADDR_W-1:0] addrOut,
  output logic              rdN,
  output logic              wrN
);

  seqCtl_t ctl;

  busCycleSeqCtrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .cmdDelay (cmdDelay),
    .ready    (ready),
    .ctl      (ctl),
    .reqAccept(reqAccept)
  );

  busCycleSeqPath #(.ADDR_W(ADDR_W)) path_i (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .reqWrite(reqWrite),
    .reqAddr (reqAddr),
    .status  (status),
    .ale     (ale),
    .addrOut (addrOut),
    .rdN     (rdN),
    .wrN     (wrN)
  );

endmodule

// File: rtl/busCycleSeqChk.sv
module busCycleSeqChk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              ready,
  input logic              reqAccept,
  input logic [1:0]        status,
  input logic              ale,
  input logic [ADDR_W-1:0] addrOut,
  input logic              rdN,
  input logic              wrN
);

  // R2
  accept_then_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqAccept |=> ale);

  // R3
  status_single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ale |=> !ale);

  // R3
  status_code_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    ale == (status != 2'b11));

  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ale |-> $stable(addrOut));

  // R6
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rdN == 1'b0 && wrN == 1'b0));

  // R7
  read_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rdN && ready) |=> rdN);

  // R7
  write_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!wrN && ready) |=> wrN);

endmodule

bind busCycleSeq busCycleSeqChk #(.ADDR_W(ADDR_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .ready    (ready),
  .reqAccept(reqAccept),
  .status   (status),
  .ale      (ale),
  .addrOut  (addrOut),
  .rdN      (rdN),
  .wrN      (wrN)
);

// File: tb/busCycleSeq_tb_top.sv
module busCycleSeq_tb_top;

  localparam int AW = 24;
  localparam logic [AW-1:0] STRAY = 24'hABCDEF;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0, reqWrite = 1'b0, cmdDelay = 1'b0, ready = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic          reqAccept, ale, rdN, wrN;
  logic [1:0]    status;
  logic [AW-1:0] addrOut;

  int errors = 0;
  int checks = 0;
  logic [AW-1:0] curAddr = '0;

  typedef struct {
    logic [1:0]    st;
    logic          al;
    logic [AW-1:0] ad;
    logic          rd;
    logic          wr;
    logic          acc;
    string         tag;
  } exp_t;

  exp_t expQ[$];

  always #4 clk = ~clk;

  busCycleSeq #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .cmdDelay(cmdDelay), .ready(ready),
    .reqAccept(reqAccept), .status(status), .ale(ale), .addrOut(addrOut),
    .rdN(rdN), .wrN(wrN)
  );

  task automatic compare(exp_t e);
    checks++;
    if (status !== e.st || ale !== e.al || addrOut !== e.ad || rdN !== e.rd ||
        wrN !== e.wr || reqAccept !== e.acc) begin
      errors++;
      $display("FAIL %s: got st=%b ale=%b addr=%h rdN=%b wrN=%b acc=%b exp st=%b ale=%b addr=%h rdN=%b wrN=%b acc=%b",
               e.tag, status, ale, addrOut, rdN, wrN, reqAccept,
               e.st, e.al, e.ad, e.rd, e.wr, e.acc);
    end
  endtask

  // monitor: late in each cycle, pop and compare
  initial begin
    forever begin
      @(posedge clk);
      #6;
      if (expQ.size() > 0) compare(expQ.pop_front());
    end
  end

  // driver step: drive inputs just after the edge and push the expected outputs of this cycle
  task automatic step(bit v, bit w, logic [AW-1:0] a, bit cd, bit rdy,
                      logic [1:0] st, bit al, logic [AW-1:0] ad,
                      bit rd, bit wr, bit acc, string tag);
    exp_t e;
    @(posedge clk);
    #1;
    reqValid = v; reqWrite = w; reqAddr = a; cmdDelay = cd; ready = rdy;
    e.st = st; e.al = al; e.ad = ad; e.rd = rd; e.wr = wr; e.acc = acc; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic idleStep(bit v, bit w, logic [AW-1:0] a, bit noise);
    step(v, w, a, noise, noise, 2'b11, 1'b0, curAddr, 1'b1, 1'b1, v,
         v ? "R1 R2 idle accept" : "R1 idle hold");
  endtask

  task automatic xfer(bit w, logic [AW-1:0] a, int nDel, int nWait, bit noise,
                      bit nxtV, bit nxtW, logic [AW-1:0] nxtA);
    // status state: stray request and ready must be ignored
    step(noise, ~w, noise ? STRAY : a, (nDel > 0), noise,
         w ? 2'b10 : 2'b01, 1'b1, a, 1'b1, 1'b1, 1'b0, "R3 R4 R8 status state");
    curAddr = a;
    for (int j = 0; j <= nWait; j++) begin
      bit last = (j == nWait);
      bit act  = (j >= nDel);
      step(last ? nxtV : noise, last ? nxtW : 1'b0, last ? nxtA : STRAY,
           ((j + 1) < nDel), last,
           2'b11, 1'b0, a, !(act && !w), !(act && w), last && nxtV,
           last ? "R5 R6 R7 final command" : "R5 R6 R8 command wait");
    end
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #6;
    checks++;
    if (status !== 2'b11 || ale !== 1'b0 || rdN !== 1'b1 || wrN !== 1'b1) begin
      errors++;
      $display("FAIL R1 reset: got st=%b ale=%b rdN=%b wrN=%b exp st=11 ale=0 rdN=1 wrN=1",
               status, ale, rdN, wrN);
    end
    @(negedge clk);
    rstN = 1'b1;
    idleStep(1'b0, 1'b0, '0, 1'b1);
    idleStep(1'b0, 1'b0, '0, 1'b1);
    idleStep(1'b1, 1'b0, 24'h000123, 1'b0);
    xfer(1'b0, 24'h000123, 0, 0, 1'b0, 1'b1, 1'b1, 24'h0ABCD0);
    xfer(1'b1, 24'h0ABCD0, 2, 3, 1'b1, 1'b1, 1'b0, 24'h55AA55);
    xfer(1'b0, 24'h55AA55, 1, 1, 1'b1, 1'b0, 1'b0, '0);
    idleStep(1'b0, 1'b0, '0, 1'b1);
    idleStep(1'b1, 1'b1, 24'hFFFFFF, 1'b0);
    xfer(1'b1, 24'hFFFFFF, 0, 4, 1'b0, 1'b0, 1'b0, '0);
    idleStep(1'b0, 1'b0, '0, 1'b0);
    idleStep(1'b0, 1'b0, '0, 1'b1);
    repeat (3) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule